// File: doc/BRIEF.md
# Port Replacement Bus Interface

This block sits on the multiplexed address/data bus of an 8-bit microcontroller that runs in expanded mode. It rebuilds two general-purpose ports that the controller gives up for its bus: an output-only port B and a bidirectional port C with its own direction register and an input latch. The host reaches these registers through ordinary bus cycles. ALE marks the address phase on the shared lines, E marks the data phase, and R/W chooses between a write and a read that the block drives back onto the shared lines.

The block sees only the top four address bits. Its register page therefore answers at every address whose top nibble matches, across a whole 4 KB window. It keeps its own copy of the page-relocation register. Only the first write after reset takes effect, and a write through any alias is accepted, so the copy can end up out of step with the host's own copy. An active-low chip select lets outside logic narrow the window. All inputs are sampled on the block clock.

Top module: `portrep_bus`

## Requirements
- R1: After reset, port B data, port C data, port C direction and the port C latch are all zero. The relocation register reads $10, so the register page is the one whose top address nibble is 1.
- R2: The block is selected when chip select is low and the four high address lines equal the page nibble. The low address byte alone picks the register, so every address in the 4 KB window aliases the page.
- R3: When ALE goes from high to low, the value on ad_in is captured as the low address byte, which is the register offset.
- R4: A write happens in the first cycle that E is high, if rw is 0 and the block is selected. Offset $04 writes port B data, which appears on pb_out.
- R5: Offset $03 is port C data and offset $07 is port C direction, where a 1 bit makes that pin an output. A read of $03 returns the data register on output bits and the pc_in pin on input bits.
- R6: ad_oe is high only while E is high, rw is 1 and the block is selected. At all other times ad_out is zero and the lines are released.
- R7: When cs_n is high, no write takes effect and no read drives the bus, whatever the address.
- R8: Offset $05 is the port C latch. It captures pc_in on each rising edge of pc_stb, and bus writes to it are ignored.
- R9: A read of any other offset returns zero, and a write to it changes no register.
- R10: Offset $3D is the relocation register, and its upper nibble is the page nibble. A write through any alias, such as $143D, moves the page.
- R11: Only the first write to the relocation register after reset is accepted. Later writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_in | input | 8 | Multiplexed address/data lines, as seen by the block |
| ad_out | output | 8 | Read data driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for ad_out |
| addr_hi | input | 4 | Top four address lines |
| ale | input | 1 | Address latch enable |
| e | input | 1 | Data phase strobe |
| rw | input | 1 | 1 for read, 0 for write |
| cs_n | input | 1 | Active-low chip select |
| pc_in | input | 8 | Port C pin levels |
| pc_stb | input | 1 | Port C latch strobe |
| pb_out | output | 8 | Port B pins |
| pc_out | output | 8 | Port C output data |
| pc_dir | output | 8 | Port C per-pin output enable |

## Verification
The bench aims at aliasing. It writes and reads the page through addresses that differ only in bits A8 to A11. A decoder that used those bits would miss these accesses and leave the ports unchanged. The bench relocates the page through a shadow address, then checks that the old page no longer drives the bus and that a second relocation write is ignored. A design that locked the register late or decoded it from the wrong nibble would read back the wrong page. Drive enable is compared with the model on every clock, so a read that leaked outside E, into another page or past a high chip select shows up as contention. A port C read mixes pin and register bits by direction, and a swapped mix returns the wrong bits.

// File: rtl/prb_pkg.sv
package prb_pkg;

    localparam int DW = 8;

    localparam logic [DW-1:0] OFF_PC    = 8'h03;
    localparam logic [DW-1:0] OFF_PB    = 8'h04;
    localparam logic [DW-1:0] OFF_LATCH = 8'h05;
    localparam logic [DW-1:0] OFF_DIR   = 8'h07;
    localparam logic [DW-1:0] OFF_INIT  = 8'h3D;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_PB,
        RS_PC,
        RS_DIR,
        RS_LATCH,
        RS_INIT
    } reg_sel_e;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [DW-1:0] off;
        logic [DW-1:0] wdata;
    } bus_evt_t;

    function automatic reg_sel_e decode_off(input logic [DW-1:0] off);
        case (off)
            OFF_PB:    return RS_PB;
            OFF_PC:    return RS_PC;
            OFF_DIR:   return RS_DIR;
            OFF_LATCH: return RS_LATCH;
            OFF_INIT:  return RS_INIT;
            default:   return RS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/prb_bus_front.sv
module prb_bus_front import prb_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ad_in,
    input  logic          ale,
    input  logic          e,
    input  logic          rw,
    input  logic          sel,
    output bus_evt_t      evt
);

    logic          ale_q;
    logic          e_q;
    logic [DW-1:0] addr_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q   <= 1'b0;
            e_q     <= 1'b0;
            addr_lo <= '0;
        end else begin
            ale_q <= ale;
            e_q   <= e;
            if (ale_q && !ale)
                addr_lo <= ad_in;
        end
    end

    always_comb begin
        evt.wr    = e && !e_q && !rw && sel;
        evt.rd    = e && rw && sel;
        evt.off   = addr_lo;
        evt.wdata = ad_in;
    end

    // R3
    addr_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (ale_q && !ale) |=> (evt.off == $past(ad_in)));

endmodule

// File: rtl/prb_page.sv
module prb_page import prb_pkg::*; #(
    parameter int PAGE_W   = 4,
    parameter int RST_PAGE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] addr_hi,
    input  logic              cs_n,
    input  bus_evt_t          evt,
    output logic              sel,
    output logic [DW-1:0]     init_q
);

    localparam logic [DW-1:0] INIT_RST = DW'(RST_PAGE) << (DW - PAGE_W);

    logic locked;
    logic init_wr;

    assign init_wr = evt.wr && (decode_off(evt.off) == RS_INIT) && !locked;
    assign sel     = !cs_n && (addr_hi == init_q[DW-1 -: PAGE_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q <= INIT_RST;
            locked <= 1'b0;
        end else if (init_wr) begin
            init_q <= evt.wdata;
            locked <= 1'b1;
        end
    end

    // R11
    init_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $past(locked) |-> $stable(init_q));

    // R10
    page_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(init_q) |-> $past(evt.wr && evt.off == OFF_INIT));

endmodule

// File: rtl/prb_regs.sv
module prb_regs import prb_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  logic [DW-1:0] init_q,
    input  logic [DW-1:0] pc_in,
    input  logic          pc_stb,
    output logic [DW-1:0] pb_q,
    output logic [DW-1:0] pc_q,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] latch_q;
    logic          stb_q;
    reg_sel_e      rsel;

    assign rsel = decode_off(evt.off);

    always_ff @(posedge clk) begin
        if (rst) begin
            pb_q    <= '0;
            pc_q    <= '0;
            dir_q   <= '0;
            latch_q <= '0;
            stb_q   <= 1'b0;
        end else begin
            stb_q <= pc_stb;
            if (pc_stb && !stb_q)
                latch_q <= pc_in;
            if (evt.wr) begin
                case (rsel)
                    RS_PB:   pb_q  <= evt.wdata;
                    RS_PC:   pc_q  <= evt.wdata;
                    RS_DIR:  dir_q <= evt.wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rsel)
            RS_PB:    rdata = pb_q;
            RS_PC:    rdata = (pc_q & dir_q) | (pc_in & ~dir_q);
            RS_DIR:   rdata = dir_q;
            RS_LATCH: rdata = latch_q;
            RS_INIT:  rdata = init_q;
            default:  rdata = '0;
        endcase
    end

    // R4
    pb_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pb_q) |-> $past(evt.wr && evt.off == OFF_PB));

    // R8
    latch_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(latch_q) |-> $past(pc_stb && !stb_q));

endmodule

// File: rtl/portrep_bus.sv
module portrep_bus import prb_pkg::*; #(
    parameter int PAGE_W   = 4,
    parameter int RST_PAGE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     ad_in,
    output logic [DW-1:0]     ad_out,
    output logic              ad_oe,
    input  logic [PAGE_W-1:0] addr_hi,
    input  logic              ale,
    input  logic              e,
    input  logic              rw,
    input  logic              cs_n,
    input  logic [DW-1:0]     pc_in,
    input  logic              pc_stb,
    output logic [DW-1:0]     pb_out,
    output logic [DW-1:0]     pc_out,
    output logic [DW-1:0]     pc_dir
);

    bus_evt_t      evt;
    logic          sel;
    logic [DW-1:0] init_q;
    logic [DW-1:0] rdata;

    prb_bus_front u_front (
        .clk(clk), .rst(rst), .ad_in(ad_in), .ale(ale), .e(e),
        .rw(rw), .sel(sel), .evt(evt)
    );

    prb_page #(.PAGE_W(PAGE_W), .RST_PAGE(RST_PAGE)) u_page (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .cs_n(cs_n),
        .evt(evt), .sel(sel), .init_q(init_q)
    );

    prb_regs u_regs (
        .clk(clk), .rst(rst), .evt(evt), .init_q(init_q),
        .pc_in(pc_in), .pc_stb(pc_stb), .pb_q(pb_out),
        .pc_q(pc_out), .dir_q(pc_dir), .rdata(rdata)
    );

    assign ad_oe  = evt.rd;
    assign ad_out = ad_oe ? rdata : '0;

    // R6
    drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (e && rw));

    // R7
    cs_block_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!ad_oe && $stable(pb_out) && $stable(pc_out) && $stable(pc_dir)));

endmodule

// File: tb/test_portrep_bus.sv
`timescale 1ns/1ps
module test_portrep_bus;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [3:0] addr_hi = 4'h0;
    logic       ale = 1'b0, e = 1'b0, rw = 1'b1, cs_n = 1'b0, pc_stb = 1'b0;
    logic [7:0] pc_in = 8'h00;
    logic [7:0] ad_out, pb_out, pc_out, pc_dir;
    logic       ad_oe;

    always #2.5 clk = ~clk;

    portrep_bus i_portrep_bus (
        .clk(clk), .rst(rst), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .ale(ale), .e(e), .rw(rw), .cs_n(cs_n),
        .pc_in(pc_in), .pc_stb(pc_stb), .pb_out(pb_out), .pc_out(pc_out),
        .pc_dir(pc_dir)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // next input values, applied by step()
    logic [7:0] d_ad = 0, d_pcin = 0;
    logic [3:0] d_hi = 0;
    logic d_ale = 0, d_e = 0, d_rw = 1, d_cs = 0, d_stb = 0;

    // reference model state
    logic [7:0] m_pb = 0, m_pc = 0, m_dir = 0, m_lat = 0, m_init = 8'h10, m_off = 0;
    bit m_lock = 0;
    logic p_ale = 0, p_e = 0, p_stb = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] off);
        case (off)
            8'h04: return m_pb;
            8'h03: return (m_pc & m_dir) | (pc_in & ~m_dir);
            8'h07: return m_dir;
            8'h05: return m_lat;
            8'h3D: return m_init;
            default: return 8'h00;
        endcase
    endfunction

    task automatic step();
        bit exp_oe, sel, wr;
        @(negedge clk);
        // compare outputs against the model
        exp_oe = e && rw && !cs_n && (addr_hi == m_init[7:4]);
        chk(pb_out == m_pb, "R4 pb_out", pb_out, m_pb);
        chk(pc_out == m_pc, "R5 pc_out", pc_out, m_pc);
        chk(pc_dir == m_dir, "R5 pc_dir", pc_dir, m_dir);
        chk(ad_oe == exp_oe, "R6 ad_oe", ad_oe, exp_oe);
        if (exp_oe)
            chk(ad_out == m_read(m_off), "R2 ad_out", ad_out, m_read(m_off));
        else
            chk(ad_out == 8'h00, "R6 ad_out idle", ad_out, 0);
        // apply next inputs
        ad_in = d_ad; addr_hi = d_hi; ale = d_ale; e = d_e; rw = d_rw;
        cs_n = d_cs; pc_in = d_pcin; pc_stb = d_stb;
        // model the coming clock edge
        sel = !d_cs && (d_hi == m_init[7:4]);
        wr  = d_e && !p_e && !d_rw && sel;
        if (wr) begin
            case (m_off)
                8'h04: m_pb = d_ad;
                8'h03: m_pc = d_ad;
                8'h07: m_dir = d_ad;
                8'h3D: if (!m_lock) begin m_init = d_ad; m_lock = 1; end
                default: ;
            endcase
        end
        if (d_stb && !p_stb) m_lat = d_pcin;
        if (p_ale && !d_ale) m_off = d_ad;
        p_ale = d_ale; p_e = d_e; p_stb = d_stb;
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] v, input bit cs);
        d_cs = cs; d_hi = a[15:12]; d_ad = a[7:0]; d_rw = 0; d_ale = 1; step();
        d_ale = 0; step();
        d_e = 1; d_ad = v; step();
        d_e = 0; step();
        d_rw = 1; d_cs = 0; step();
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [7:0] expv,
                          input bit drive, input bit cs, input string tag);
        d_cs = cs; d_hi = a[15:12]; d_ad = a[7:0]; d_rw = 1; d_ale = 1; step();
        d_ale = 0; step();
        d_e = 1; d_ad = 8'h00; step();
        @(posedge clk); #1;
        chk(ad_oe == drive, {tag, " drive"}, ad_oe, drive);
        if (drive) chk(ad_out == expv, {tag, " data"}, ad_out, expv);
        d_e = 0; step();
        d_cs = 0; step();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        step();
        // R1 reset state
        chk(pb_out == 8'h00 && pc_dir == 8'h00 && pc_out == 8'h00, "R1 ports", pb_out, 0);
        bus_rd(16'h103D, 8'h10, 1, 0, "R1 init");
        bus_rd(16'h1005, 8'h00, 1, 0, "R1 latch");
        // R3 R4 port B write and read back
        bus_wr(16'h1004, 8'hA5, 0);
        chk(pb_out == 8'hA5, "R4 pb write", pb_out, 8'hA5);
        bus_rd(16'h1004, 8'hA5, 1, 0, "R3 pb read");
        // R2 aliasing across A8..A11
        bus_wr(16'h1F04, 8'h3C, 0);
        chk(pb_out == 8'h3C, "R2 alias write", pb_out, 8'h3C);
        bus_rd(16'h1804, 8'h3C, 1, 0, "R2 alias read");
        // R7 chip select blocks
        bus_wr(16'h1004, 8'hFF, 1);
        chk(pb_out == 8'h3C, "R7 cs write", pb_out, 8'h3C);
        bus_rd(16'h1004, 8'h3C, 0, 1, "R7 cs read");
        // R2 other page ignored
        bus_wr(16'h2004, 8'h11, 0);
        chk(pb_out == 8'h3C, "R2 other page", pb_out, 8'h3C);
        bus_rd(16'h2004, 8'h00, 0, 0, "R6 other page read");
        // R5 port C mixing
        bus_wr(16'h1007, 8'hF0, 0);
        bus_wr(16'h1003, 8'hA0, 0);
        d_pcin = 8'h5C; step();
        chk(pc_dir == 8'hF0, "R5 dir", pc_dir, 8'hF0);
        bus_rd(16'h1003, 8'hAC, 1, 0, "R5 pc mix");
        // R8 latch
        d_pcin = 8'h99; step();
        d_stb = 1; step();
        d_stb = 0; d_pcin = 8'h00; step();
        bus_rd(16'h1005, 8'h99, 1, 0, "R8 latch");
        bus_wr(16'h1005, 8'h12, 0);
        bus_rd(16'h1005, 8'h99, 1, 0, "R8 latch ro");
        // R9 unmapped offset
        bus_wr(16'h1010, 8'h55, 0);
        bus_rd(16'h1010, 8'h00, 1, 0, "R9 unmapped");
        bus_rd(16'h1004, 8'h3C, 1, 0, "R9 pb kept");
        // R10 relocation through a shadow address
        bus_wr(16'h143D, 8'h30, 0);
        bus_rd(16'h3004, 8'h3C, 1, 0, "R10 new page");
        bus_rd(16'h1004, 8'h00, 0, 0, "R10 old page");
        bus_rd(16'h3A3D, 8'h30, 1, 0, "R10 init read");
        // R11 second relocation write ignored
        bus_wr(16'h303D, 8'h50, 0);
        bus_rd(16'h3004, 8'h3C, 1, 0, "R11 page kept");
        bus_rd(16'h5004, 8'h00, 0, 0, "R11 no move");
        bus_rd(16'h303D, 8'h30, 1, 0, "R11 init kept");
        repeat (3) step();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule